// File: doc/BRIEF.md
# Thermal Clock Modulation Controller

This block lowers the average power of a core by switching the core's clock-enable on and off in a repeating pattern. The controller has two sources for the on-fraction. The first is a thermal path: while the hot-temperature input is high, the controller applies a fixed duty code that is set by a parameter at build time and that software cannot change. The second is an on-demand path: software writes an enable flag and a 3-bit duty code through a single write strobe. When both sources are active, the thermal path wins.

A modulation period has eight equal slots, and each slot lasts `SLOT_CYCLES` reference clocks. For an applied code N, the clock-enable is high for the first N slots of each period and low for the remaining slots. A new code, or a new source, is applied only at a period boundary, so a period never ends partway through its pattern. While the enable is low, the block holds incoming interrupt requests and delivers them in the first cycle that the clock runs again. The snoop-enable output stays high throughout, so bus snoop handling is not affected by clock gating.

Top module: `clk_mod_ctrl`

## Requirements
- R1: While reset is asserted, `core_clk_en_o` is 1, `therm_active_o` is 0, `irq_hold_o` is 0, `irq_o` is 0 and `snoop_en_o` is 1.
- R2: When the hot input is low and the software enable is 0, `core_clk_en_o` stays 1 and `therm_active_o` stays 0.
- R3: A period has 8 slots of `SLOT_CYCLES` clocks each. For an applied code N in 1..7, `core_clk_en_o` is 1 during slots 0..N-1 and 0 during slots N..7.
- R4: If software enables the on-demand path with code 0, `core_clk_en_o` stays 1 and `therm_active_o` stays 0.
- R5: If the hot input is high at a period boundary, the next period uses `FACTORY_CODE` (default 3, which gives 37.5 % on time) and `therm_active_o` reads 1 for that period.
- R6: While the hot input is high, the software enable and code have no effect on `core_clk_en_o`.
- R7: The source and the code sampled in the last cycle of a period take effect from the first cycle of the next period. A change made at any other time does not alter the period that is already running.
- R8: `irq_hold_o` is 1 exactly when `core_clk_en_o` is 0.
- R9: A request bit that arrives while `core_clk_en_o` is 0 is held, and it appears on `irq_o` in the first cycle with `core_clk_en_o` = 1. While `core_clk_en_o` is 1, `irq_o` is the current requests OR'ed with the held bits. While `core_clk_en_o` is 0, `irq_o` is 0.
- R10: `snoop_en_o` stays 1 at all times, whether the clock is gated or not.
- R11: The software enable and code are loaded only in a cycle with `sw_wr_i` = 1. Changes to `sw_en_i` or `sw_code_i` without the strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hot_i | input | 1 | Over-temperature indication; selects the thermal path |
| sw_wr_i | input | 1 | Write strobe for the on-demand setting |
| sw_en_i | input | 1 | On-demand enable, loaded when `sw_wr_i` is 1 |
| sw_code_i | input | 3 | On-demand duty code in eighths of on time, loaded when `sw_wr_i` is 1 |
| irq_req_i | input | IRQ_W | Incoming interrupt requests |
| core_clk_en_o | output | 1 | Clock-enable pulse train for the core |
| therm_active_o | output | 1 | 1 while the running period uses the thermal duty code |
| irq_hold_o | output | 1 | 1 while requests are being held because the clock is off |
| irq_o | output | IRQ_W | Requests passed to the core while its clock runs |
| snoop_en_o | output | 1 | Snoop enable; stays 1 during modulation |

## Verification
The assertions check the following on every cycle: the slot counter returns to slot 0 after the period wrap, the applied code changes only at a wrap, the thermal source wins whenever it is sampled, the thermal status always matches the factory code, and a request held during an off cycle is delivered when the clock turns back on. The bench scenarios check the complete on/off waveform of every duty code. They also check that the hot input overrides software and that software writes without the strobe are ignored. A sweep that starts and stops the hot input at each phase of the period checks that the pattern changes only at a period boundary, which no single-cycle property can show.

// File: rtl/clk_mod_pkg.sv
package clk_mod_pkg;
  localparam int CODE_W = 3;
  localparam int SLOTS  = 1 << CODE_W;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SOFT  = 2'd1,
    SRC_THERM = 2'd2
  } duty_src_e;
endpackage

// File: rtl/clk_mod_timer.sv
module clk_mod_timer
  import clk_mod_pkg::*;
#(
  parameter int SLOT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [CODE_W-1:0] slot_o,
  output logic              wrap_o
);
  localparam int CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CODE_W-1:0] SLOT_LAST = CODE_W'(SLOTS - 1);

  logic              slot_step;
  logic [CODE_W-1:0] slot_q, slot_d;

  generate
    if (SLOT_CYCLES == 1) begin : g_no_div
      assign slot_step = 1'b1;
    end else begin : g_div
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYCLES - 1);
      logic [CNT_W-1:0] cnt_q, cnt_d;

      always_comb begin
        if (cnt_q == CNT_LAST) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign slot_step = (cnt_q == CNT_LAST);
    end
  endgenerate

  always_comb begin
    slot_d = slot_q;
    if (slot_step) slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot_o = slot_q;
  assign wrap_o = slot_step && (slot_q == SLOT_LAST);

  // R3: after the last cycle of a period the timer is back in slot 0
  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (slot_o == '0));
endmodule

// File: rtl/clk_mod_select.sv
module clk_mod_select
  import clk_mod_pkg::*;
#(
  parameter int FACTORY_CODE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_i,
  input  logic              hot_i,
  input  logic              sw_en_i,
  input  logic [CODE_W-1:0] sw_code_i,
  output logic [CODE_W-1:0] code_o,
  output duty_src_e         src_o
);
  localparam logic [CODE_W-1:0] FACT = CODE_W'(FACTORY_CODE);

  logic [CODE_W-1:0] req_code, code_q, code_d;
  duty_src_e         req_src, src_q, src_d;

  // fixed priority: thermal path, then software, then free running
  always_comb begin
    if (hot_i) begin
      req_code = FACT;
      req_src  = SRC_THERM;
    end else if (sw_en_i) begin
      req_code = sw_code_i;
      req_src  = SRC_SOFT;
    end else begin
      req_code = '0;
      req_src  = SRC_NONE;
    end
  end

  always_comb begin
    code_d = code_q;
    src_d  = src_q;
    if (wrap_i) begin
      code_d = req_code;
      src_d  = req_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      src_q  <= SRC_NONE;
    end else begin
      code_q <= code_d;
      src_q  <= src_d;
    end
  end

  assign code_o = code_q;
  assign src_o  = src_q;

  // R7: the applied code never moves except at a period wrap
  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(code_o));

  // R6: a hot sample at the wrap always installs the factory code
  p_hot_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && hot_i) |=> (code_o == FACT && src_o == SRC_THERM));

  // R5: thermal ownership implies the factory duty
  p_therm_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_o == SRC_THERM) |-> (code_o == FACT));
endmodule

// File: rtl/clk_mod_ctrl.sv
module clk_mod_ctrl
  import clk_mod_pkg::*;
#(
  parameter int SLOT_CYCLES  = 4,
  parameter int FACTORY_CODE = 3,
  parameter int IRQ_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hot_i,
  input  logic              sw_wr_i,
  input  logic              sw_en_i,
  input  logic [CODE_W-1:0] sw_code_i,
  input  logic [IRQ_W-1:0]  irq_req_i,
  output logic              core_clk_en_o,
  output logic              therm_active_o,
  output logic              irq_hold_o,
  output logic [IRQ_W-1:0]  irq_o,
  output logic              snoop_en_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // software on-demand setting
  logic              cfg_en_q, cfg_en_d;
  logic [CODE_W-1:0] cfg_code_q, cfg_code_d;

  always_comb begin
    cfg_en_d   = cfg_en_q;
    cfg_code_d = cfg_code_q;
    if (sw_wr_i) begin
      cfg_en_d   = sw_en_i;
      cfg_code_d = sw_code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cfg_en_q   <= 1'b0;
      cfg_code_q <= '0;
    end else begin
      cfg_en_q   <= cfg_en_d;
      cfg_code_q <= cfg_code_d;
    end
  end

  // period timer and duty source selection
  logic [CODE_W-1:0] slot;
  logic              wrap;
  logic [CODE_W-1:0] code;
  duty_src_e         src;

  clk_mod_timer #(
    .SLOT_CYCLES(SLOT_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_q),
    .slot_o(slot),
    .wrap_o(wrap)
  );

  clk_mod_select #(
    .FACTORY_CODE(FACTORY_CODE)
  ) u_select (
    .clk      (clk),
    .rst_n    (rst_q),
    .wrap_i   (wrap),
    .hot_i    (hot_i),
    .sw_en_i  (cfg_en_q),
    .sw_code_i(cfg_code_q),
    .code_o   (code),
    .src_o    (src)
  );

  // gate: on for the first `code` slots, code 0 means never gated
  logic clk_en;
  assign clk_en = (code == '0) || (slot < code);

  // interrupt holding while the clock is stopped
  logic [IRQ_W-1:0] held_q, held_d;

  always_comb begin
    if (clk_en) held_d = '0;
    else        held_d = held_q | irq_req_i;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) held_q <= '0;
    else        held_q <= held_d;
  end

  logic snoop_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) snoop_q <= 1'b1;
    else        snoop_q <= 1'b1;
  end

  assign core_clk_en_o  = clk_en;
  assign therm_active_o = (src == SRC_THERM);
  assign irq_hold_o     = !clk_en;
  assign irq_o          = clk_en ? (irq_req_i | held_q) : '0;
  assign snoop_en_o     = snoop_q;

  // R9: a request seen in a gated cycle is delivered when the clock returns
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (core_clk_en_o && !$past(core_clk_en_o) && $past(irq_req_i[0])) |-> irq_o[0]);

  // R4: a software code of zero never stops the clock
  p_zero_code_on_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (src == SRC_SOFT && code == '0) |-> core_clk_en_o);
endmodule

// File: tb/clk_mod_ctrl_test.sv
module clk_mod_ctrl_test;
  localparam int S     = 2;
  localparam int F     = 3;
  localparam int IW    = 4;
  localparam int P     = 8 * S;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hot_i;
  logic          sw_wr_i;
  logic          sw_en_i;
  logic [2:0]    sw_code_i;
  logic [IW-1:0] irq_req_i;
  logic          core_clk_en_o;
  logic          therm_active_o;
  logic          irq_hold_o;
  logic [IW-1:0] irq_o;
  logic          snoop_en_o;

  always #4 clk = ~clk;

  clk_mod_ctrl #(.SLOT_CYCLES(S), .FACTORY_CODE(F), .IRQ_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .sw_wr_i(sw_wr_i),
    .sw_en_i(sw_en_i), .sw_code_i(sw_code_i), .irq_req_i(irq_req_i),
    .core_clk_en_o(core_clk_en_o), .therm_active_o(therm_active_o),
    .irq_hold_o(irq_hold_o), .irq_o(irq_o), .snoop_en_o(snoop_en_o)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  // arithmetic model: edges since reset release, phase, applied code
  int n = 0;
  int ph = 0;
  int m_code = 0;
  bit m_therm = 1'b0;
  bit m_en = 1'b0;
  int m_cd = 0;
  logic [IW-1:0] m_held = '0;

  function automatic bit exp_en(int code, int phase);
    return (code == 0) || ((phase / S) < code);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; ph = 0; m_code = 0; m_therm = 1'b0;
      m_en = 1'b0; m_cd = 0; m_held = '0;
    end else begin
      bit pre_en;
      pre_en = exp_en(m_code, ph);
      if (n >= 2 && ph == P - 1) begin
        m_therm = hot_i;
        m_code  = hot_i ? F : (m_en ? m_cd : 0);
      end
      if (n >= 2) m_held = pre_en ? '0 : (m_held | irq_req_i);
      if (n >= 2 && sw_wr_i) begin
        m_en = sw_en_i;
        m_cd = int'(sw_code_i);
      end
      n = n + 1;
      ph = (n >= 2) ? (n - 2) % P : 0;
    end
  end

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at phase %0d", t, what, act, exp, ph);
    end
  endtask

  // sample between the rising edge and the falling edge
  always @(posedge clk) begin
    #3;
    if (!done) begin
      bit e;
      e = exp_en(m_code, ph);
      chk(tag, "core_clk_en_o", int'(core_clk_en_o), int'(e));
      chk((tag == "R1") ? "R1" : "R5", "therm_active_o", int'(therm_active_o), int'(m_therm));
      chk("R8", "irq_hold_o", int'(irq_hold_o), int'(!e));
      chk("R9", "irq_o", int'(irq_o), e ? int'(irq_req_i | m_held) : 0);
      chk("R10", "snoop_en_o", int'(snoop_en_o), 1);
    end
  end

  task automatic run(int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic write_sw(bit en, int code);
    @(negedge clk);
    sw_wr_i = 1'b1; sw_en_i = en; sw_code_i = 3'(code);
    @(negedge clk);
    sw_wr_i = 1'b0;
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    summary();
  end

  initial begin
    logic [7:0] lfsr;
    rst_n = 1'b0; hot_i = 1'b0; sw_wr_i = 1'b0; sw_en_i = 1'b0;
    sw_code_i = '0; irq_req_i = '0;
    tag = "R1";
    run(5);
    rst_n = 1'b1;
    tag = "R2";
    run(3 * P);

    // R3: every software code over whole periods
    tag = "R3";
    for (int c = 1; c < 8; c++) begin
      write_sw(1'b1, c);
      run(3 * P);
    end

    // R4: enable with code 0
    tag = "R4";
    write_sw(1'b1, 0);
    run(3 * P);

    // R11: field changes without strobe are ignored
    tag = "R11";
    write_sw(1'b0, 0);
    run(P);
    sw_en_i = 1'b1; sw_code_i = 3'd6;
    run(3 * P);
    sw_en_i = 1'b0; sw_code_i = 3'd0;

    // R5: thermal path alone
    tag = "R5";
    hot_i = 1'b1;
    run(3 * P);

    // R6: software setting ignored while hot
    tag = "R6";
    write_sw(1'b1, 7);
    run(3 * P);
    write_sw(1'b1, 1);
    run(2 * P);
    hot_i = 1'b0;

    // R7: changes at every phase only act at the boundary
    tag = "R7";
    write_sw(1'b1, 6);
    for (int off = 0; off < P; off++) begin
      run(off + 1);
      hot_i = 1'b1;
      run(P + 3);
      hot_i = 1'b0;
      write_sw(1'b1, (off % 7) + 1);
    end
    run(2 * P);

    // R9: request traffic across gated and running cycles
    tag = "R9";
    write_sw(1'b1, 2);
    lfsr = 8'hA5;
    for (int k = 0; k < 6 * P; k++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      irq_req_i = (lfsr[7:6] == 2'b11) ? lfsr[3:0] : '0;
    end
    @(negedge clk);
    irq_req_i = '0;
    write_sw(1'b0, 0);
    tag = "R2";
    run(3 * P);

    done = 1'b1;
    summary();
  end
endmodule